// File: doc/BRIEF.md
# Power-up reset timeout sequencer

This block holds a small processor core in reset after a power-on event, a brown-out event or a wake from sleep. It then releases the core once the required start-up delays have passed. Two timers run one after the other. The first is a power-up delay that counts ticks from a slow, independent time base. The second is an oscillator settling count that counts cycles of the main clock. Whether each timer runs depends on the kind of event, on the oscillator mode and on a disable bit for the power-up delay.

The delays are counted from the event pulse, not from the release of the external active-low clear pin. If that pin is held low long enough, both delays expire while it is low, and the core leaves reset as soon as the synchronized pin reads high. The configuration is captured when a sequence starts. A new power-on or brown-out pulse restarts the sequence from the beginning.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until the first power-on or brown-out sequence completes, core_rst_o is high and timeout_done_o is low.
- R2: A power-on pulse with pwrt_dis_i=0 in a crystal mode runs PWRT_TICKS slow ticks and then OST_CYCLES clock cycles. core_rst_o falls after the clock edge that samples the last tick, plus OST_CYCLES further edges.
- R3: The oscillator mode is coded on osc_mode_i as 2'b00 low-power crystal, 2'b01 standard crystal, 2'b10 high-speed crystal and 2'b11 RC. The settling count runs only in the three crystal codes and is skipped for 2'b11.
- R4: pwrt_dis_i=1 skips the power-up delay. With pwrt_dis_i=1 and RC mode, core_rst_o is low right after the edge that samples the pulse.
- R5: A brown-out pulse follows the same timer rules as a power-on pulse.
- R6: A wake pulse that arrives while no sequence is running applies only the settling count in crystal modes, and no delay in RC mode. A wake pulse during a running sequence, or before the first sequence, has no effect.
- R7: The delays run while mclr_ni is low. Once they have expired, core_rst_o falls after the second clock edge that samples mclr_ni high.
- R8: core_rst_o is high whenever the synchronized mclr_ni is low or a timer is still running.
- R9: A power-on or brown-out pulse during a sequence aborts it, clears both counts and restarts from the first stage.
- R10: timeout_done_o clears when a power-on or brown-out sequence starts and sets when the last timer of that sequence finishes. It also sets at once when the sequence has no timer.
- R11: pwrt_dis_i and osc_mode_i are sampled when a sequence starts. Changing them during the sequence does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the block |
| slow_tick_i | input | 1 | One-cycle tick from the slow independent time base |
| por_pulse_i | input | 1 | Power-on detected pulse |
| bor_pulse_i | input | 1 | Brown-out detected pulse |
| wake_i | input | 1 | Wake-from-sleep pulse |
| mclr_ni | input | 1 | External active-low clear pin, asynchronous |
| pwrt_dis_i | input | 1 | 1 disables the power-up delay |
| osc_mode_i | input | 2 | Oscillator mode code (see R3) |
| core_rst_o | output | 1 | Reset to the core, active high |
| timeout_done_o | output | 1 | Start-up delays of the last sequence completed |
| pwrt_busy_o | output | 1 | Power-up delay running |
| ost_busy_o | output | 1 | Oscillator settling count running |

## Verification
The hardest case to reach is a restart that lands inside a partly counted power-up delay. If the count were not cleared, the new sequence would finish early by exactly the ticks already consumed. The bench therefore drives the slow tick itself on a fixed schedule that starts at each pulse. This makes every release cycle exact. A restart after two ticks must then yield the full delay again. A second hard case holds the clear pin low through both delays and then counts the edges after its release.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;
  typedef enum logic [1:0] {
    OSC_LP = 2'b00,
    OSC_XT = 2'b01,
    OSC_HS = 2'b10,
    OSC_RC = 2'b11
  } osc_mode_e;

  typedef enum logic [1:0] {
    ST_HOLD = 2'b00,
    ST_PWRT = 2'b01,
    ST_OST  = 2'b10,
    ST_RUN  = 2'b11
  } seq_st_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // resets low so the pin reads as asserted clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assign last_o = en_i & at_last;
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int unsigned PWRT_TICKS  = 8,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_tick_i,
  input  logic       por_pulse_i,
  input  logic       bor_pulse_i,
  input  logic       wake_i,
  input  logic       mclr_ni,
  input  logic       pwrt_dis_i,
  input  logic [1:0] osc_mode_i,
  output logic       core_rst_o,
  output logic       timeout_done_o,
  output logic       pwrt_busy_o,
  output logic       ost_busy_o
);
  seq_st_e   state_q, state_d;
  osc_mode_e mode_q;
  logic      done_q, done_d;
  logic      mclr_q;
  logic      cold_start, warm_start;
  logic      xtal_new, xtal_q;
  logic      pwrt_last, ost_last;

  pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mclr_ni),
    .q_o    (mclr_q)
  );

  assign cold_start = por_pulse_i | bor_pulse_i;
  assign warm_start = wake_i & ~cold_start & (state_q == ST_RUN);
  assign xtal_new   = (osc_mode_e'(osc_mode_i) != OSC_RC);
  assign xtal_q     = (mode_q != OSC_RC);

  step_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cold_start | (state_q != ST_PWRT)),
    .en_i   (slow_tick_i & (state_q == ST_PWRT)),
    .last_o (pwrt_last)
  );

  step_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cold_start | warm_start | (state_q != ST_OST)),
    .en_i   (state_q == ST_OST),
    .last_o (ost_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    if (cold_start) begin
      done_d = 1'b0;
      if (!pwrt_dis_i)   state_d = ST_PWRT;
      else if (xtal_new) state_d = ST_OST;
      else begin
        state_d = ST_RUN;
        done_d  = 1'b1;
      end
    end else if (warm_start) begin
      if (xtal_new) state_d = ST_OST;
    end else begin
      unique case (state_q)
        ST_PWRT: if (pwrt_last) begin
          if (xtal_q) state_d = ST_OST;
          else begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end
        end
        ST_OST: if (ost_last) begin
          state_d = ST_RUN;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      done_q  <= 1'b0;
      mode_q  <= OSC_RC;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cold_start | warm_start) mode_q <= osc_mode_e'(osc_mode_i);
    end
  end

  assign core_rst_o     = ~mclr_q | (state_q != ST_RUN);
  assign timeout_done_o = done_q;
  assign pwrt_busy_o    = (state_q == ST_PWRT);
  assign ost_busy_o     = (state_q == ST_OST);
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk
  import pwrup_rst_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_pulse_i,
  input logic       bor_pulse_i,
  input logic       wake_i,
  input logic       mclr_ni,
  input logic       pwrt_dis_i,
  input logic [1:0] osc_mode_i,
  input logic       core_rst_o,
  input logic       timeout_done_o,
  input logic [1:0] state_q,
  input logic [1:0] mode_q
);
  // R8
  rel_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_o |-> $past(mclr_ni, 2));

  // R10
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_done_o) |-> state_q == ST_RUN);

  // R9
  cold_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_pulse_i || bor_pulse_i) && !pwrt_dis_i |=> state_q == ST_PWRT && !timeout_done_o);

  // R4
  no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_pulse_i || bor_pulse_i) && pwrt_dis_i && osc_mode_i == OSC_RC
      |=> state_q == ST_RUN && timeout_done_o);

  // R6
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i && !por_pulse_i && !bor_pulse_i && state_q == ST_HOLD |=> state_q == ST_HOLD);

  // R3
  rc_no_ost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OST |-> mode_q != OSC_RC);

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_pulse_i && !bor_pulse_i && (state_q == ST_PWRT || state_q == ST_OST)
      |=> $stable(mode_q));
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .por_pulse_i    (por_pulse_i),
  .bor_pulse_i    (bor_pulse_i),
  .wake_i         (wake_i),
  .mclr_ni        (mclr_ni),
  .pwrt_dis_i     (pwrt_dis_i),
  .osc_mode_i     (osc_mode_i),
  .core_rst_o     (core_rst_o),
  .timeout_done_o (timeout_done_o),
  .state_q        (state_q),
  .mode_q         (mode_q)
);

// File: tb/tb_pwrup_rst_seq.sv
module tb_pwrup_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;
  localparam int N = 1024;
  localparam int G = 5;
  localparam int K_POR = 0, K_BOR = 1, K_WAKE = 2;
  localparam logic [1:0] LP = 2'b00, XT = 2'b01, HS = 2'b10, RC = 2'b11;

  typedef struct packed {
    logic [1:0] kind;
    logic       dis;
    logic [1:0] mode;
    int         exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'(K_POR),  1'b0, XT, P*G+N},  // R2
    '{2'(K_POR),  1'b0, RC, P*G},    // R3
    '{2'(K_POR),  1'b1, HS, N},      // R4
    '{2'(K_POR),  1'b1, RC, 0},      // R4
    '{2'(K_BOR),  1'b0, LP, P*G+N},  // R5
    '{2'(K_BOR),  1'b0, RC, P*G},    // R5
    '{2'(K_WAKE), 1'b0, XT, N},      // R6
    '{2'(K_WAKE), 1'b0, RC, 0}       // R6
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic slow_tick = 1'b0, por = 1'b0, bor = 1'b0, wake = 1'b0;
  logic mclr_n = 1'b1, pwrt_dis = 1'b0;
  logic [1:0] osc_mode = XT;
  logic core_rst, done, pwrt_busy, ost_busy;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_rst_seq #(.PWRT_TICKS(P), .OST_CYCLES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick),
    .por_pulse_i(por), .bor_pulse_i(bor), .wake_i(wake),
    .mclr_ni(mclr_n), .pwrt_dis_i(pwrt_dis), .osc_mode_i(osc_mode),
    .core_rst_o(core_rst), .timeout_done_o(done),
    .pwrt_busy_o(pwrt_busy), .ost_busy_o(ost_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start_evt(input int kind, input logic dis, input logic [1:0] mode);
    @(negedge clk);
    pwrt_dis = dis; osc_mode = mode;
    por  = (kind == K_POR);
    bor  = (kind == K_BOR);
    wake = (kind == K_WAKE);
    @(posedge clk);
    @(negedge clk);
    por = 1'b0; bor = 1'b0; wake = 1'b0;
  endtask

  // drive ticks on the fixed schedule for n cycles
  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = ((i + 1) % G == 0);
      @(posedge clk);
      @(negedge clk);
    end
    slow_tick = 1'b0;
  endtask

  // extra: 0 none, 1 flip config after start, 2 poke wake after start
  task automatic run_seq(input int kind, input logic dis, input logic [1:0] mode,
                         input int exp, input int extra, input string req);
    int cnt;
    start_evt(kind, dis, mode);
    if (extra == 1) begin
      pwrt_dis = ~dis; osc_mode = ~mode;
    end
    if (extra == 2) wake = 1'b1;
    if (kind != K_WAKE && exp > 0)
      check(done == 1'b0, "R10 done cleared at start", int'(done), 0);
    cnt = 0;
    while (core_rst && cnt < 5000) begin
      slow_tick = ((cnt + 1) % G == 0);
      @(posedge clk);
      wake = 1'b0;
      @(negedge clk);
      cnt++;
    end
    slow_tick = 1'b0; wake = 1'b0;
    check(cnt == exp, req, cnt, exp);
    check(done == 1'b1, "R10 done set at end", int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 3);
    check(core_rst == 1'b1, "R1 rst held in reset", int'(core_rst), 1);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    @(negedge clk); rst_ni = 1'b1;
    // wake before any sequence: ignored (R6)
    start_evt(K_WAKE, 1'b1, RC);
    run_cycles(20);
    check(core_rst == 1'b1, "R1 R6 held before first sequence", int'(core_rst), 1);
    check(done == 1'b0, "R1 done low before first sequence", int'(done), 0);

    foreach (VECS[i])
      run_seq(int'(VECS[i].kind), VECS[i].dis, VECS[i].mode, VECS[i].exp, 0,
              "R2 R3 R4 R5 R6 vector release cycle");

    // R11: config changed mid-sequence is ignored
    run_seq(K_POR, 1'b0, RC, P*G, 1, "R11 config held");
    // R6: wake during running sequence ignored
    run_seq(K_POR, 1'b1, XT, N, 2, "R6 wake ignored mid-sequence");

    // R9: restart inside a partly counted power-up delay
    start_evt(K_POR, 1'b0, RC);
    run_cycles(2*G);
    run_seq(K_POR, 1'b0, RC, P*G, 0, "R9 restart clears delay count");
    // R9: brown-out aborting settling count
    start_evt(K_POR, 1'b1, XT);
    run_cycles(100);
    run_seq(K_BOR, 1'b1, XT, N, 0, "R9 restart clears settling count");

    // R7 R8: pin held low through both delays
    @(negedge clk); mclr_n = 1'b0;
    run_cycles(3);
    start_evt(K_POR, 1'b0, XT);
    run_cycles(P*G + N + 20);
    check(core_rst == 1'b1, "R8 pin low holds reset", int'(core_rst), 1);
    check(done == 1'b1, "R7 delays expire under pin low", int'(done), 1);
    mclr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(core_rst == 1'b1, "R7 still held after one edge", int'(core_rst), 1);
    @(posedge clk); @(negedge clk);
    check(core_rst == 1'b0, "R7 release after second edge", int'(core_rst), 0);

    // R8: pin low during run reasserts reset
    mclr_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(core_rst == 1'b1, "R8 pin low reasserts", int'(core_rst), 1);
    mclr_n = 1'b1;
    run_cycles(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule